// File: doc/BRIEF.md
# Learning-Based DRAM Command Scheduler

This block picks the next DRAM command by acting as a reinforcement-learning agent. In every cycle it reduces a set of transaction-queue statistics to a compact state. The statistics are the counts of reads, writes and load misses, the number of pending writes and of reorder-buffer heads that wait on the referenced row, and the relative age order of the candidate request. The block holds a value table with one signed fixed-point entry per state and command. It offers the highest-valued command among those that an external timing checker marks as allowed.

The table learns at run time. The block earns a reward of one unit in a cycle that issues a read or a write that is accepted, and zero in every other cycle. At the clock edge after a decision, the entry for that decision moves one sixteenth of the way toward the reward plus the discounted value of the command that was just chosen. The discount is fifteen sixteenths. A synchronous reset fills the whole table with a value taken from an input port. Timing checks, the request queue and the physical interface lie outside the block.

Top module: `rl_cmd_sched`

## Requirements
- R1: `cmdOut` carries the command code: 0 activate, 1 write, 2 read for a load miss, 3 read for a store miss, 4 precharge with requests pending, 5 preemptive precharge, 6 no-operation; the code 7 never appears.
- R2: Each attribute k (k = 0..5, field `attrCnt[4k+3:4k]`) is quantised to q = min(count >> 1, 1), so counts 0 and 1 give 0 and counts 2 and up give 1. The state index is the sum of q_k << k, and every state has its own row of values.
- R3: A command whose bit in `cmdLegal` is 0 is never chosen. No-operation (code 6) is always allowed, whatever `cmdLegal[6]` holds, so `cmdLegal[5:0] == 0` gives code 6.
- R4: Among the allowed commands the one with the largest signed value is chosen; on equal values the lower code wins.
- R5: A clock edge with `rst` high loads every table entry with `initValue`, so in the first cycle after reset `cmdValue` equals `initValue`.
- R6: The reward for a decision is 256 (1.0 in a format with 8 fraction bits) when the chosen code is 1, 2 or 3 and `cmdAccept` is high in that cycle; it is 0 otherwise.
- R7: At the edge that ends the cycle after a decision (s,a) with reward r, the entry becomes Q + ((r + N - (N >>> 4)) - Q) >>> 4. Here N is the `cmdValue` shown in that later cycle, and the shifts are arithmetic (they round toward minus infinity).
- R8: `cmdValue` equals the stored value of the chosen command in the current state, and it follows the inputs in the same cycle.
- R9: The first edge after reset updates no entry, so in the second cycle after reset every entry still holds `initValue`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset; loads the table |
| initValue | input | 16 | Value loaded into every entry on reset |
| attrCnt | input | 24 | Six 4-bit queue statistics, attribute k in bits 4k+3:4k |
| cmdLegal | input | 7 | Per-command allowed flags from the timing checker |
| cmdAccept | input | 1 | The offered command was issued this cycle |
| cmdOut | output | 3 | Chosen command code |
| cmdValue | output | 16 | Signed value of the chosen command |

## Verification
The bench goes after ties. A selector that favoured the higher code would pick no-operation right after reset, when every entry is equal. A masking fault would pick a disallowed command or would read `cmdLegal[6]` and fail to fall back to no-operation. Reward faults are probed by training with and without `cmdAccept`, where a scheduler that rewarded unaccepted or non-data commands would drift away from the reference values. The quantiser's count boundary between 1 and 2 is driven to show that neighbouring states share or separate rows correctly. Updates that used the wrong next value, that rounded toward zero, or that fired on the first edge after reset would miscompare within a few cycles, both against the fixed-point reference and against the negative reset value used in the second run.

// File: rtl/rl_sched_pkg.sv
package rl_sched_pkg;
  localparam int NUM_ACT = 7;

  typedef enum logic [2:0] {
    A_ACT  = 3'd0,
    A_WR   = 3'd1,
    A_RDL  = 3'd2,
    A_RDS  = 3'd3,
    A_PREP = 3'd4,
    A_PREE = 3'd5,
    A_NOP  = 3'd6
  } act_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic wrEn;
    logic reward;
  } updStrobe_t;
endpackage

// File: rtl/rl_sched_argmax.sv
module rl_sched_argmax
  import rl_sched_pkg::*;
#(
  parameter int VAL_W = 16
) (
  input  logic [NUM_ACT-1:0][VAL_W-1:0] vals,
  input  logic [NUM_ACT-1:0]            legal,
  output act_e                          bestAct,
  output logic [VAL_W-1:0]              bestVal
);
  // Scan from the top code down; >= lets a lower code take over a tie.
  always_comb begin
    bestAct = A_NOP;
    bestVal = vals[NUM_ACT-1];
    for (int a = NUM_ACT - 2; a >= 0; a--) begin
      if (legal[a] && ($signed(vals[a]) >= $signed(bestVal))) begin
        bestAct = act_e'(a[2:0]);
        bestVal = vals[a];
      end
    end
  end
endmodule

// File: rtl/rl_sched_ctrl.sv
module rl_sched_ctrl
  import rl_sched_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmdAccept,
  input  act_e       chosen,
  output updStrobe_t strb
);
  logic primed;
  logic rewardQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      primed  <= 1'b0;
      rewardQ <= 1'b0;
    end else begin
      primed  <= 1'b1;
      rewardQ <= cmdAccept && (chosen inside {A_WR, A_RDL, A_RDS});
    end
  end

  assign strb.clear  = rst;
  assign strb.wrEn   = primed && !rst;
  assign strb.reward = rewardQ;
endmodule

// File: rtl/rl_sched_dpath.sv
module rl_sched_dpath
  import rl_sched_pkg::*;
#(
  parameter int NUM_ATTR = 6,
  parameter int CNT_W    = 4,
  parameter int QBITS    = 1,
  parameter int QSHIFT   = 1,
  parameter int VAL_W    = 16,
  parameter int FRAC     = 8,
  parameter int ALPHA_SH = 4,
  parameter int GAMMA_SH = 4
) (
  input  logic                      clk,
  input  updStrobe_t                strb,
  input  logic [VAL_W-1:0]          initValue,
  input  logic [NUM_ATTR*CNT_W-1:0] attrCnt,
  input  logic [NUM_ACT-1:0]        cmdLegal,
  output act_e                      bestAct,
  output logic [VAL_W-1:0]          bestVal
);
  localparam int STATE_W   = NUM_ATTR * QBITS;
  localparam int NUM_STATE = 1 << STATE_W;
  localparam int EXT_W     = VAL_W + 4;
  localparam logic [CNT_W-1:0] QMAX = CNT_W'((1 << QBITS) - 1);
  localparam logic signed [EXT_W-1:0] ONE = EXT_W'(1) <<< FRAC;

  logic [STATE_W-1:0] stateIdx;
  logic [STATE_W-1:0] prevState;
  act_e               prevAct;

  // saturating quantiser, one per attribute
  for (genvar k = 0; k < NUM_ATTR; k++) begin : g_quant
    logic [CNT_W-1:0] shifted;
    assign shifted = attrCnt[k*CNT_W +: CNT_W] >> QSHIFT;
    assign stateIdx[k*QBITS +: QBITS] =
      (shifted > QMAX) ? QMAX[QBITS-1:0] : shifted[QBITS-1:0];
  end

  logic signed [VAL_W-1:0] qTab [NUM_STATE][NUM_ACT];

  logic [NUM_ACT-1:0][VAL_W-1:0] rowVals;
  for (genvar a = 0; a < NUM_ACT; a++) begin : g_row
    assign rowVals[a] = qTab[stateIdx][a];
  end

  rl_sched_argmax #(.VAL_W(VAL_W)) u_argmax (
    .vals   (rowVals),
    .legal  (cmdLegal | 7'b1000000),
    .bestAct(bestAct),
    .bestVal(bestVal)
  );

  // value update arithmetic
  logic signed [VAL_W-1:0] oldVal;
  logic signed [EXT_W-1:0] oldW, nxtW, discW, tgtW, deltaW, newW;

  assign oldVal = qTab[prevState][prevAct];
  assign oldW   = EXT_W'(oldVal);
  assign nxtW   = EXT_W'($signed(bestVal));
  assign discW  = nxtW - (nxtW >>> GAMMA_SH);
  assign tgtW   = discW + (strb.reward ? ONE : '0);
  assign deltaW = tgtW - oldW;
  assign newW   = oldW + (deltaW >>> ALPHA_SH);

  always_ff @(posedge clk) begin
    prevState <= stateIdx;
    prevAct   <= bestAct;
  end

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      for (int s = 0; s < NUM_STATE; s++)
        for (int a = 0; a < NUM_ACT; a++)
          qTab[s][a] <= initValue;
    end else if (strb.wrEn) begin
      qTab[prevState][prevAct] <= newW[VAL_W-1:0];
    end
  end
endmodule

// File: rtl/rl_cmd_sched.sv
module rl_cmd_sched
  import rl_sched_pkg::*;
#(
  parameter int NUM_ATTR = 6,
  parameter int CNT_W    = 4,
  parameter int QBITS    = 1,
  parameter int QSHIFT   = 1,
  parameter int VAL_W    = 16,
  parameter int FRAC     = 8,
  parameter int ALPHA_SH = 4,
  parameter int GAMMA_SH = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [VAL_W-1:0]          initValue,
  input  logic [NUM_ATTR*CNT_W-1:0] attrCnt,
  input  logic [NUM_ACT-1:0]        cmdLegal,
  input  logic                      cmdAccept,
  output logic [2:0]                cmdOut,
  output logic [VAL_W-1:0]          cmdValue
);
  updStrobe_t strb;
  act_e       bestAct;

  rl_sched_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cmdAccept(cmdAccept),
    .chosen   (bestAct),
    .strb     (strb)
  );

  rl_sched_dpath #(
    .NUM_ATTR(NUM_ATTR), .CNT_W(CNT_W), .QBITS(QBITS), .QSHIFT(QSHIFT),
    .VAL_W(VAL_W), .FRAC(FRAC), .ALPHA_SH(ALPHA_SH), .GAMMA_SH(GAMMA_SH)
  ) u_dpath (
    .clk      (clk),
    .strb     (strb),
    .initValue(initValue),
    .attrCnt  (attrCnt),
    .cmdLegal (cmdLegal),
    .bestAct  (bestAct),
    .bestVal  (cmdValue)
  );

  assign cmdOut = bestAct;
endmodule

// File: rtl/rl_cmd_sched_chk.sv
module rl_cmd_sched_chk #(
  parameter int VAL_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [VAL_W-1:0] initValue,
  input logic [6:0]       cmdLegal,
  input logic [2:0]       cmdOut,
  input logic [VAL_W-1:0] cmdValue
);
  p_code_range_r1: assert property (@(posedge clk) disable iff (rst)
    cmdOut != 3'd7);

  p_legal_pick_r3: assert property (@(posedge clk) disable iff (rst)
    (cmdOut == 3'd6) || cmdLegal[cmdOut]);

  p_nop_fallback_r3: assert property (@(posedge clk) disable iff (rst)
    (cmdLegal[5:0] == 6'd0) |-> (cmdOut == 3'd6));

  p_reset_load_r5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cmdValue == $past(initValue)));

  p_first_edge_idle_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(rst, 2) && !$past(rst)) |-> (cmdValue == $past(initValue, 2)));
endmodule

bind rl_cmd_sched rl_cmd_sched_chk #(.VAL_W(VAL_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .initValue(initValue),
  .cmdLegal (cmdLegal),
  .cmdOut   (cmdOut),
  .cmdValue (cmdValue)
);

// File: tb/rl_cmd_sched_bench.sv
`timescale 1ns/1ps
module rl_cmd_sched_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] initValue = 16'd0;
  logic [23:0] attrCnt = '0;
  logic [6:0]  cmdLegal = '0;
  logic        cmdAccept = 1'b0;
  logic [2:0]  cmdOut;
  logic [15:0] cmdValue;

  always #2 clk = ~clk;

  rl_cmd_sched u_rl_cmd_sched (
    .clk(clk), .rst(rst), .initValue(initValue), .attrCnt(attrCnt),
    .cmdLegal(cmdLegal), .cmdAccept(cmdAccept),
    .cmdOut(cmdOut), .cmdValue(cmdValue)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // reference model
  int mq [64][7];
  int ps, pa, pr;
  bit pv = 0;
  int curS, curA, curV;

  function automatic int stateOf(logic [23:0] at);
    int s = 0;
    for (int k = 0; k < 6; k++) begin
      int c = int'(at[k*4 +: 4]);
      if ((c / 2) >= 1) s += (1 << k);
    end
    return s;
  endfunction

  function automatic int updVal(int o, int r, int n);
    int tgt = n - (n >>> 4) + (r != 0 ? 256 : 0);
    return o + ((tgt - o) >>> 4);
  endfunction

  function automatic logic [23:0] mkAttr(int a0, int a1, int a2, int a3, int a4, int a5);
    return {4'(a5), 4'(a4), 4'(a3), 4'(a2), 4'(a1), 4'(a0)};
  endfunction

  task automatic checkEq(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock cycle: drive, compare against model, advance model
  task automatic step(string tag, bit r, logic [23:0] at, logic [6:0] lg, bit acc);
    @(negedge clk);
    rst = r; attrCnt = at; cmdLegal = lg; cmdAccept = acc;
    #1;
    if (!r) begin
      curS = stateOf(at);
      curA = -1;
      curV = 0;
      for (int a = 0; a < 7; a++) begin
        if ((a == 6 || lg[a]) && (curA < 0 || mq[curS][a] > curV)) begin
          curA = a;
          curV = mq[curS][a];
        end
      end
      checkEq({tag, " cmd R4"}, int'(cmdOut), curA);
      checkEq({tag, " value R8"}, int'($signed(cmdValue)), curV);
      if (pv) mq[ps][pa] = updVal(mq[ps][pa], pr, curV);
      ps = curS; pa = curA;
      pr = (acc && curA >= 1 && curA <= 3) ? 1 : 0;
      pv = 1;
    end else begin
      for (int s = 0; s < 64; s++)
        for (int a = 0; a < 7; a++) mq[s][a] = int'($signed(initValue));
      pv = 0;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    logic [23:0] stA;
    logic [23:0] stB;
    stA = mkAttr(0, 0, 0, 0, 0, 0);
    stB = mkAttr(0, 0, 0, 2, 0, 0);

    // R5: reset loads the initial value
    initValue = 16'd256;
    step("R5 reset", 1, stA, 7'h7f, 0);
    step("R5 reset", 1, stA, 7'h7f, 0);
    step("R5 first", 0, stA, 7'h7f, 0);
    checkEq("R5 init value", int'($signed(cmdValue)), 256);
    checkEq("R4 tie lowest code", int'(cmdOut), 0);

    // R3: masking and no-op fallback
    step("R3 mask", 0, stA, 7'h00, 0);
    checkEq("R3 nop fallback R1", int'(cmdOut), 6);
    step("R3 mask", 0, stA, 7'h24, 0);
    checkEq("R3 masked pick", int'(cmdOut), 2);

    // R9 / R7 / R6: fresh reset with zero values
    initValue = 16'd0;
    step("R9 reset", 1, stA, 7'h02, 1);
    step("R9 c0", 0, stA, 7'h02, 1);
    step("R9 c1", 0, stA, 7'h02, 1);
    checkEq("R9 no first update", int'($signed(cmdValue)), 0);
    step("R7 c2", 0, stA, 7'h02, 1);
    checkEq("R7 one step", int'($signed(cmdValue)), 16);
    checkEq("R1 write code", int'(cmdOut), 1);
    for (int i = 0; i < 40; i++) step("R7 train", 0, stA, 7'h02, 1);

    // R2: neighbouring state keeps its own row; count 1 maps with 0
    step("R2 other state", 0, stB, 7'h02, 1);
    checkEq("R2 untouched row", int'($signed(cmdValue)), 0);
    step("R2 boundary", 0, mkAttr(1, 1, 1, 1, 1, 1), 7'h02, 1);
    checkEq("R2 count one shares row", int'(cmdValue != 16'd0), 1);

    // R6: unaccepted data commands and non-data commands earn nothing
    for (int i = 0; i < 20; i++) step("R6 no accept", 0, stB, 7'h08, 0);
    for (int i = 0; i < 20; i++) step("R6 precharge", 0, stB, 7'h10, 1);
    step("R6 check", 0, stB, 7'h18, 0);
    checkEq("R6 zero reward row", int'($signed(cmdValue)), 0);

    // R4: trained write beats everything once all are allowed
    step("R4 argmax", 0, stA, 7'h7f, 0);
    checkEq("R4 trained pick", int'(cmdOut), 1);

    // random traffic, negative initial value
    initValue = 16'hfed4;
    step("R5 reset neg", 1, stA, 7'h7f, 0);
    step("R5 neg first", 0, stA, 7'h7f, 0);
    checkEq("R5 neg init", int'($signed(cmdValue)), -300);
    for (int i = 0; i < 4000; i++) begin
      logic [23:0] at;
      at = mkAttr(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                  0, int'($urandom_range(0, 2)), 0, int'($urandom_range(0, 15)));
      step("R8 random", 0, at, 7'($urandom), 1'($urandom));
    end

    finishRun();
  end
endmodule